// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the line and frame timing for a TFT-style LCD panel. Software supplies, at run time, the length of each horizontal region in pixel clocks and the length of each vertical region in whole lines: the sync pulse, the back porch, the active region and the front porch. The block drives horizontal sync, vertical sync and an output-enable (data valid) strobe, together with the active pixel column and line index. It also raises a one-cycle frame interrupt at a chosen vertical phase. Scanning is progressive only.

Every line visits four regions in a fixed order: the sync pulse, the back porch, the active pixels and the front porch. The vertical axis uses the same order, and it advances once per completed line. The eight geometry values are captured into shadow registers while the block is idle and at every frame wrap, so a frame never mixes old and new values. The three polarity controls and the interrupt phase select act at once. A global enable starts and stops the raster with one cycle of latency. Every region length is expected to be at least one.

Top module: `lcd_raster_gen`

## Requirements
- R1: After reset, and while the generator is stopped, each sync and enable output sits at its inactive level, frame_irq is 0, and pix_x and line_y are 0.
- R2: Counting from cycle 0 of a line, hsync is active for h_sync_len cycles. A line lasts h_sync_len+h_back_len+h_act_len+h_front_len cycles.
- R3: vsync is active during the first v_sync_len lines of a frame, which is v_sync_len whole line times. A frame lasts v_sync_len+v_back_len+v_act_len+v_front_len lines.
- R4: oe is active only where the horizontal position is inside the active pixels and the line is inside the active lines. That gives exactly h_act_len*v_act_len enabled cycles per frame.
- R5: While oe is active, pix_x counts 0 to h_act_len-1 across the line and line_y gives the active line index starting at 0. Outside oe both are 0.
- R6: hs_inv, vs_inv and oe_inv each act on their own output. With the bit at 0 the output is active high, and with the bit at 1 it is active low. The bits take effect in the same cycle.
- R7: frame_irq pulses during cycle 0 of one line per frame. irq_phase 0 selects the first sync line, 1 the first back-porch line (v_sync_len), 2 the first active line (v_sync_len+v_back_len), and 3 the first front-porch line (v_sync_len+v_back_len+v_act_len).
- R8: frame_irq is high for a single cycle and occurs exactly once per frame.
- R9: A geometry change made mid-frame does not affect the current frame. It applies from the first cycle of the next frame.
- R10: The generator runs one cycle after en is sampled high and stops one cycle after en is sampled low. Each start begins a fresh frame at line 0, cycle 0, in the sync region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global run enable |
| h_sync_len | input | CW | Horizontal sync width, pixel clocks |
| h_back_len | input | CW | Horizontal back porch, pixel clocks |
| h_act_len | input | CW | Active pixels per line |
| h_front_len | input | CW | Horizontal front porch, pixel clocks |
| v_sync_len | input | CW | Vertical sync width, lines |
| v_back_len | input | CW | Vertical back porch, lines |
| v_act_len | input | CW | Active lines per frame |
| v_front_len | input | CW | Vertical front porch, lines |
| hs_inv | input | 1 | 1 makes hsync active low |
| vs_inv | input | 1 | 1 makes vsync active low |
| oe_inv | input | 1 | 1 makes oe active low |
| irq_phase | input | 2 | Vertical phase of the frame interrupt |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| oe | output | 1 | Output enable / data valid |
| pix_x | output | CW | Active pixel column |
| line_y | output | CW | Active line index |
| frame_irq | output | 1 | One-cycle frame interrupt |

## Verification
All outputs are decoded without further registers from the two position counters, so a position is visible in the cycle that follows the edge that loaded it. The enable adds exactly one register stage, and a geometry change takes effect at the edge where the frame wraps. The bench keeps a position model that it advances at each rising edge, using the same enable and shadow-load points. It compares every output at the following falling edge, which puts each check in the cycle where that result is due. Frame totals for oe and the interrupt are counted over windows aligned to frame starts.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } vphase_e;

  // Length of one axis period (line in clocks, frame in lines).
  function automatic logic [31:0] axis_total(logic [31:0] s, logic [31:0] b,
                                             logic [31:0] a, logic [31:0] f);
    return s + b + a + f;
  endfunction

  // Line index at which the selected vertical phase begins.
  function automatic logic [31:0] phase_line(vphase_e sel, logic [31:0] s,
                                             logic [31:0] b, logic [31:0] a);
    case (sel)
      PH_SYNC:   return 32'd0;
      PH_BACK:   return s;
      PH_ACTIVE: return s + b;
      default:   return s + b + a;
    endcase
  endfunction

endpackage

// File: rtl/lcd_cfg_shadow.sv
module lcd_cfg_shadow #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/lcd_axis_ctr.sv
module lcd_axis_ctr
  import lcd_raster_pkg::*;
#(
  parameter int CW = 12,
  localparam int TW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] len_sync,
  input  logic [CW-1:0] len_back,
  input  logic [CW-1:0] len_act,
  input  logic [CW-1:0] len_front,
  output logic [TW-1:0] cnt,
  output logic          last,
  output logic          in_sync,
  output logic          in_act,
  output logic [CW-1:0] coord
);
  logic [TW-1:0] total, act_lo, act_hi;

  always_comb begin
    total  = TW'(axis_total(32'(len_sync), 32'(len_back),
                            32'(len_act), 32'(len_front)));
    act_lo = TW'(len_sync) + TW'(len_back);
    act_hi = act_lo + TW'(len_act);
    last    = (cnt == total - TW'(1));
    in_sync = (cnt < TW'(len_sync));
    in_act  = (cnt >= act_lo) && (cnt < act_hi);
    coord   = in_act ? CW'(cnt - act_lo) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (step) cnt <= last ? '0 : cnt + TW'(1);
  end
endmodule

// File: rtl/lcd_frame_irq.sv
module lcd_frame_irq
  import lcd_raster_pkg::*;
#(
  parameter int CW = 12,
  localparam int TW = CW + 2
) (
  input  logic          run,
  input  logic [TW-1:0] h_cnt,
  input  logic [TW-1:0] v_cnt,
  input  logic [CW-1:0] v_sync,
  input  logic [CW-1:0] v_back,
  input  logic [CW-1:0] v_act,
  input  vphase_e       sel,
  output logic          irq
);
  logic [TW-1:0] tgt_line;
  always_comb begin
    tgt_line = TW'(phase_line(sel, 32'(v_sync), 32'(v_back), 32'(v_act)));
    irq      = run && (h_cnt == '0) && (v_cnt == tgt_line);
  end
endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_raster_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] h_sync_len,
  input  logic [CW-1:0] h_back_len,
  input  logic [CW-1:0] h_act_len,
  input  logic [CW-1:0] h_front_len,
  input  logic [CW-1:0] v_sync_len,
  input  logic [CW-1:0] v_back_len,
  input  logic [CW-1:0] v_act_len,
  input  logic [CW-1:0] v_front_len,
  input  logic          hs_inv,
  input  logic          vs_inv,
  input  logic          oe_inv,
  input  logic [1:0]    irq_phase,
  output logic          hsync,
  output logic          vsync,
  output logic          oe,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] line_y,
  output logic          frame_irq
);
  localparam int TW = CW + 2;
  localparam int NF = 8;

  logic run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= en;
  end

  // Geometry shadow: idx 0..3 horizontal, 4..7 vertical.
  logic [CW-1:0] cfg_d [NF];
  logic [CW-1:0] cfg_q [NF];
  logic          load;
  logic          frame_end;

  assign cfg_d[0] = h_sync_len;
  assign cfg_d[1] = h_back_len;
  assign cfg_d[2] = h_act_len;
  assign cfg_d[3] = h_front_len;
  assign cfg_d[4] = v_sync_len;
  assign cfg_d[5] = v_back_len;
  assign cfg_d[6] = v_act_len;
  assign cfg_d[7] = v_front_len;

  assign load = !run || frame_end;

  for (genvar i = 0; i < NF; i++) begin : g_shadow
    lcd_cfg_shadow #(.W(CW)) u_sh (
      .clk(clk), .rst_n(rst_n), .load(load), .d(cfg_d[i]), .q(cfg_q[i])
    );
  end

  logic [TW-1:0] h_cnt, v_cnt;
  logic          h_last, v_last, h_in_sync, v_in_sync, h_in_act, v_in_act;
  logic [CW-1:0] h_coord, v_coord;

  lcd_axis_ctr #(.CW(CW)) u_hctr (
    .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1),
    .len_sync(cfg_q[0]), .len_back(cfg_q[1]), .len_act(cfg_q[2]), .len_front(cfg_q[3]),
    .cnt(h_cnt), .last(h_last), .in_sync(h_in_sync), .in_act(h_in_act), .coord(h_coord)
  );

  lcd_axis_ctr #(.CW(CW)) u_vctr (
    .clk(clk), .rst_n(rst_n), .run(run), .step(h_last),
    .len_sync(cfg_q[4]), .len_back(cfg_q[5]), .len_act(cfg_q[6]), .len_front(cfg_q[7]),
    .cnt(v_cnt), .last(v_last), .in_sync(v_in_sync), .in_act(v_in_act), .coord(v_coord)
  );

  assign frame_end = run && h_last && v_last;

  lcd_frame_irq #(.CW(CW)) u_irq (
    .run(run), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .v_sync(cfg_q[4]), .v_back(cfg_q[5]), .v_act(cfg_q[6]),
    .sel(vphase_e'(irq_phase)), .irq(frame_irq)
  );

  // Named internal events, shared with the checker.
  logic hs_on, vs_on, oe_on;
  assign hs_on = run && h_in_sync;
  assign vs_on = run && v_in_sync;
  assign oe_on = run && h_in_act && v_in_act;

  assign hsync  = hs_on ^ hs_inv;
  assign vsync  = vs_on ^ vs_inv;
  assign oe     = oe_on ^ oe_inv;
  assign pix_x  = oe_on ? h_coord : '0;
  assign line_y = oe_on ? v_coord : '0;
endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          run,
  input logic          hs_inv,
  input logic          vs_inv,
  input logic          oe_inv,
  input logic          hsync,
  input logic          vsync,
  input logic          oe,
  input logic          frame_irq,
  input logic [CW-1:0] pix_x,
  input logic          oe_on,
  input logic          hs_on,
  input logic          frame_end
);
  p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync == hs_inv) && (vsync == vs_inv) && (oe == oe_inv) && !frame_irq);

  p_start_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> run);

  p_stop_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !run);

  p_oe_outside_hsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_on |-> !hs_on);

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  p_irq_line_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> hs_on);

  p_pix_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_on |=> (!oe_on || (pix_x == $past(pix_x) + CW'(1))));

  p_pix_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_on |-> (pix_x == '0));

  p_wrap_to_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && en) |=> hs_on);
endmodule

bind lcd_raster_gen lcd_raster_chk #(.CW(CW)) u_chk (.*);

// File: tb/lcd_raster_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_raster_gen_tb_top;
  localparam int CW = 12;
  localparam int VW = 4 + 2*CW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, en, hs_inv, vs_inv, oe_inv;
  logic [1:0] irq_phase;
  logic [CW-1:0] hsl, hbl, hal, hfl, vsl, vbl, val, vfl;
  logic hsync, vsync, oe, frame_irq;
  logic [CW-1:0] pix_x, line_y;

  lcd_raster_gen #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .h_sync_len(hsl), .h_back_len(hbl), .h_act_len(hal), .h_front_len(hfl),
    .v_sync_len(vsl), .v_back_len(vbl), .v_act_len(val), .v_front_len(vfl),
    .hs_inv(hs_inv), .vs_inv(vs_inv), .oe_inv(oe_inv), .irq_phase(irq_phase),
    .hsync(hsync), .vsync(vsync), .oe(oe), .pix_x(pix_x), .line_y(line_y),
    .frame_irq(frame_irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // Model state: position, run flag, shadowed geometry.
  int h = 0, v = 0;
  bit run_m = 0;
  int m_hs, m_hb, m_ha, m_hf, m_vs, m_vb, m_va, m_vf;
  int cnt_irq, cnt_oe;

  task automatic check(string req, bit ok, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic snap();
    m_hs = int'(hsl); m_hb = int'(hbl); m_ha = int'(hal); m_hf = int'(hfl);
    m_vs = int'(vsl); m_vb = int'(vbl); m_va = int'(val); m_vf = int'(vfl);
  endtask

  function automatic int irq_line();
    case (irq_phase)
      2'd0: return 0;
      2'd1: return m_vs;
      2'd2: return m_vs + m_vb;
      default: return m_vs + m_vb + m_va;
    endcase
  endfunction

  // One clock: advance the model at the rising edge, compare at the falling edge.
  task automatic cyc(string req);
    bit wrap;
    logic hs_a, vs_a, oe_a, irq_a;
    int px, ly;
    logic [VW-1:0] expv, actv;
    @(posedge clk);
    wrap = 0;
    if (!rst_n || !run_m) begin
      h = 0; v = 0; wrap = 1;
    end else if (h == m_hs+m_hb+m_ha+m_hf-1) begin
      h = 0;
      if (v == m_vs+m_vb+m_va+m_vf-1) begin v = 0; wrap = 1; end
      else v++;
    end else h++;
    if (wrap) snap();
    run_m = rst_n && en;
    @(negedge clk);
    hs_a  = run_m && (h < m_hs);
    vs_a  = run_m && (v < m_vs);
    oe_a  = run_m && (h >= m_hs+m_hb) && (h < m_hs+m_hb+m_ha)
                  && (v >= m_vs+m_vb) && (v < m_vs+m_vb+m_va);
    irq_a = run_m && (h == 0) && (v == irq_line());
    px = oe_a ? h - (m_hs+m_hb) : 0;
    ly = oe_a ? v - (m_vs+m_vb) : 0;
    expv = {hs_a ^ hs_inv, vs_a ^ vs_inv, oe_a ^ oe_inv, irq_a, CW'(px), CW'(ly)};
    actv = {hsync, vsync, oe, frame_irq, pix_x, line_y};
    check(req, actv === expv, "{hs,vs,oe,irq,x,y}", longint'(actv), longint'(expv));
    if (frame_irq === 1'b1) cnt_irq++;
    if (oe_a) cnt_oe++;
  endtask

  function automatic int ftot();
    return (int'(hsl)+int'(hbl)+int'(hal)+int'(hfl)) *
           (int'(vsl)+int'(vbl)+int'(val)+int'(vfl));
  endfunction

  task automatic t_reset();
    rst_n = 0; en = 0;
    hsl = 2; hbl = 3; hal = 4; hfl = 2;
    vsl = 1; vbl = 2; val = 3; vfl = 1;
    hs_inv = 0; vs_inv = 0; oe_inv = 0; irq_phase = 2'd2;
    repeat (3) cyc("R1");
    rst_n = 1;
    repeat (4) cyc("R1");
  endtask

  task automatic t_base();
    int f;
    en = 1;
    cnt_irq = 0; cnt_oe = 0;
    f = ftot();
    repeat (2*f) cyc("R2 R3 R4 R5 R7");
    check("R4", cnt_oe == 2*4*3, "oe cycles", cnt_oe, 2*4*3);
    check("R8", cnt_irq == 2, "irq count", cnt_irq, 2);
  endtask

  task automatic t_polarity();
    hs_inv = 1; repeat (ftot()) cyc("R6 hs_inv");
    hs_inv = 0; vs_inv = 1; repeat (ftot()) cyc("R6 vs_inv");
    vs_inv = 0; oe_inv = 1; repeat (ftot()) cyc("R6 oe_inv");
    oe_inv = 0;
  endtask

  task automatic t_irq_phase();
    for (int s = 0; s < 4; s++) begin
      irq_phase = 2'(s);
      cnt_irq = 0;
      repeat (ftot()) cyc("R7");
      check("R8", cnt_irq == 1, "irq per frame", cnt_irq, 1);
    end
  endtask

  task automatic t_shadow();
    int f_old;
    f_old = ftot();
    repeat (20) cyc("R9");
    hal = 5; vbl = 1; hsl = 3;
    repeat (f_old - 20) cyc("R9 old frame");
    cnt_oe = 0; cnt_irq = 0;
    repeat (ftot()) cyc("R9 new frame");
    check("R9", cnt_oe == 5*3, "oe cycles new geometry", cnt_oe, 5*3);
    check("R8", cnt_irq == 1, "irq count", cnt_irq, 1);
  endtask

  task automatic t_disable();
    repeat (30) cyc("R10");
    en = 0;
    repeat (4) cyc("R10 stopped");
    en = 1;
    cnt_oe = 0;
    repeat (ftot()) cyc("R10 restart");
    check("R10", cnt_oe == int'(hal)*int'(val), "oe after restart",
          cnt_oe, int'(hal)*int'(val));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_base();
    t_polarity();
    t_irq_phase();
    t_shadow();
    t_disable();
    finish_run();
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule